// File: doc/BRIEF.md
# Unsigned Array Multiplier with Redundant Carry

This block multiplies two N-bit unsigned operands and, in the same combinational pass, adds a carry-in held in redundant carry-save form. A carry-save value with N-1 digits is carried on two N-1 bit vectors. Bit i of each vector has weight 2^i, so the integer value is the plain sum of the two vectors. The result has two parts. One is an N-bit binary low word. The other is a carry-out, also in N-1 digit carry-save form, which carries weight 2^N.

Inside, AND gates form one partial product for each multiplier bit. These partial products feed a linear chain of N identical stages, and stage j takes multiplier bit j. Each stage is a column of full adders followed by fixed shift wiring. It emits one bit of the low word and passes a carry-save value to the next stage. No stage propagates a carry along its width, so the critical path grows with N stages of one full adder each.

Several instances can be chained to build wider products. A caller that needs the high half in binary adds the two carry-out vectors outside this block.

Top module: `csm_array_mult`

## Requirements
- R1: For all legal inputs, cin + a·b = plo + 2^N·cout holds. Here cin = cin_x + cin_y and cout = cout_x + cout_y, each taken as an unsigned integer.
- R2: Both carry-save ports are N-1 bits wide, and bit i of each vector has weight 2^i. The carry-in accepts values up to 2^N − 2, for example both vectors all ones. The carry-out value never exceeds 2^N − 2.
- R3: plo equals (cin + a·b) mod 2^N.
- R4: When a = 0 or b = 0, plo equals the carry-in value and the carry-out value is 0.
- R5: Every full adder produces sum = x xor y xor z and carry = majority(x, y, z). Equivalently, sum + 2·carry = x + y + z.
- R6: Every stage satisfies X + P = r + 2·Y. Here X is its carry-save input, P its partial product, r its low-word bit and Y its carry-save output.
- R7: Partial product j is a ANDed with b[j] on every bit. When b = 2^j and the carry-in is zero, the product value is a·2^j.
- R8: When N = 1, both carry-save ports are one bit wide and unused. The carry-in must be driven to 0, the carry-out is driven to 0, and plo = a AND b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | Multiplicand, unsigned |
| b | input | N | Multiplier, unsigned; bit j drives stage j |
| cin_x | input | max(N-1,1) | Carry-in, first vector of the carry-save pair |
| cin_y | input | max(N-1,1) | Carry-in, second vector of the carry-save pair |
| plo | output | N | Low N bits of the result, binary |
| cout_x | output | max(N-1,1) | Carry-out, first vector, weight 2^N |
| cout_y | output | max(N-1,1) | Carry-out, second vector, weight 2^N |

## Verification
The embedded checks assume that the carry-in never exceeds 2^N − 2. Every pair of N-1 bit vectors meets this bound, because each vector is at most 2^(N-1) − 1. The stimulus therefore draws both carry-in vectors freely for N ≥ 2 and drives them to zero only for N = 1. The stimulus covers every input combination for N of 1 to 4, and random vectors plus directed extremes for N = 8. The carry-out vectors are never compared bit by bit, because the carry-save form of a value is not unique; only their integer sum is compared.

// File: rtl/csm_pkg.sv
// Shared bit-level helpers for the carry-save array multiplier.
// Assumes: single-bit operands; pure functions, no state.
package csm_pkg;
    // Three-input parity, the sum output of a full adder.
    function automatic logic par3(input logic x, input logic y, input logic z);
        return x ^ y ^ z;
    endfunction

    // Three-input majority, the carry output of a full adder.
    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction
endpackage

// File: rtl/csm_fa.sv
// Single full adder.
// Assumes: the three inputs have equal weight; the carry output has double weight.
module csm_fa
    import csm_pkg::*;
(
    input  logic x,
    input  logic y,
    input  logic z,
    output logic s,
    output logic co
);
    // Sum and carry from the shared helpers.
    assign s  = par3(x, y, z);
    assign co = maj3(x, y, z);

    // Arithmetic identity of the adder.
    always_comb begin
        // R5
        fa_sum_chk: assert ({co, s} == 2'(x) + 2'(y) + 2'(z))
            else $error("full adder identity broken");
    end
endmodule

// File: rtl/csm_ppgen.sv
// Partial-product generator: row j is the multiplicand gated by multiplier bit j.
// Assumes: N >= 1; rows are indexed by multiplier bit.
module csm_ppgen #(
    parameter int N = 8
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] pp [N]
);
    // One AND row for each multiplier bit.
    for (genvar j = 0; j < N; j++) begin : g_row
        assign pp[j] = a & {N{b[j]}};
    end

    // Each row is either zero or a copy of the multiplicand, as its gating bit selects.
    always_comb begin
        for (int j = 0; j < N; j++) begin
            // R7
            pp_row_chk: assert (b[j] ? (pp[j] == a) : (pp[j] == '0))
                else $error("partial product row %0d wrong", j);
        end
    end
endmodule

// File: rtl/csm_stage.sv
// One stage of the array: adds an N-bit partial product to an N-1 digit
// carry-save value. It emits one binary bit and passes on a carry-save value
// that has been halved in weight.
// Assumes: N >= 2; X + P = r + 2*Y holds for every input.
module csm_stage #(
    parameter  int N  = 8,
    localparam int SW = N + 2
) (
    input  logic [N-2:0] x_a,
    input  logic [N-2:0] x_b,
    input  logic [N-1:0] p,
    output logic         r,
    output logic [N-2:0] y_a,
    output logic [N-2:0] y_b
);
    logic [N-2:0] s;
    logic [N-2:0] c;

    // A full adder for each digit position below the partial product MSB.
    for (genvar i = 0; i < N - 1; i++) begin : g_fa
        csm_fa u_fa (.x(p[i]), .y(x_a[i]), .z(x_b[i]), .s(s[i]), .co(c[i]));
    end

    // Shift wiring: sums move down one place, carries stay in place.
    assign r = s[0];
    for (genvar j = 0; j < N - 2; j++) begin : g_shift
        assign y_a[j] = s[j+1];
    end
    assign y_a[N-2] = p[N-1];
    assign y_b      = c;

    // Value conservation across the stage.
    logic [SW-1:0] in_val;
    logic [SW-1:0] out_val;
    always_comb begin
        in_val  = SW'(x_a) + SW'(x_b) + SW'(p);
        out_val = SW'(r) + ((SW'(y_a) + SW'(y_b)) << 1);
        // R6
        stage_value_chk: assert (in_val == out_val)
            else $error("stage value not conserved");
    end
endmodule

// File: rtl/csm_array_mult.sv
// N-by-N unsigned array multiplier with carry-save carry-in and carry-out.
// Computes cin + a*b = plo + 2^N * cout, without any carry-propagate adder.
// Assumes: the carry-in value is at most 2^N - 2 (always true for N >= 2);
// for N = 1 the carry-in must be 0. Purely combinational.
module csm_array_mult #(
    parameter  int N  = 8,
    localparam int CW = (N > 1) ? N - 1 : 1,
    localparam int TW = 2 * N + 1
) (
    input  logic [N-1:0]  a,
    input  logic [N-1:0]  b,
    input  logic [CW-1:0] cin_x,
    input  logic [CW-1:0] cin_y,
    output logic [N-1:0]  plo,
    output logic [CW-1:0] cout_x,
    output logic [CW-1:0] cout_y
);
    logic [N-1:0] pp [N];

    // Partial products.
    csm_ppgen #(.N(N)) u_pp (.a(a), .b(b), .pp(pp));

    if (N == 1) begin : g_single
        // Single bit: the product is one AND gate and no carry arises.
        assign plo    = pp[0];
        assign cout_x = '0;
        assign cout_y = '0;

        // Carry-in must be zero for a one-bit multiplier.
        always_comb begin
            // R8
            single_cin_chk: assert ((cin_x == '0) && (cin_y == '0))
                else $error("carry-in must be zero when N is 1");
        end
    end else begin : g_array
        logic [CW-1:0] ch_a [N+1];
        logic [CW-1:0] ch_b [N+1];

        // Carry-in enters the chain at stage 0.
        assign ch_a[0] = cin_x;
        assign ch_b[0] = cin_y;

        // Chain of stages, one for each multiplier bit.
        for (genvar j = 0; j < N; j++) begin : g_stage
            csm_stage #(.N(N)) u_stage (
                .x_a(ch_a[j]), .x_b(ch_b[j]), .p(pp[j]),
                .r(plo[j]), .y_a(ch_a[j+1]), .y_b(ch_b[j+1])
            );
        end

        // The carry-save value left after the last stage is the carry-out.
        assign cout_x = ch_a[N];
        assign cout_y = ch_b[N];

        // Whole-block identity and carry-out bound.
        logic [TW-1:0] lhs;
        logic [TW-1:0] rhs;
        logic [TW-1:0] cout_val;
        always_comb begin
            lhs      = TW'(cin_x) + TW'(cin_y) + TW'(a) * TW'(b);
            cout_val = TW'(cout_x) + TW'(cout_y);
            rhs      = TW'(plo) + (cout_val << N);
            // R1
            product_identity_chk: assert (lhs == rhs)
                else $error("product identity broken");
            // R2
            cout_bound_chk: assert (cout_val <= (TW'(1) << N) - TW'(2))
                else $error("carry-out value above bound");
        end
    end
endmodule

// File: tb/csm_array_mult_test.sv
// Bench: exhaustive sweeps for N = 1..4, random and directed vectors for N = 8.
module csm_array_mult_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // N = 8 instance
    logic [7:0] a8 = '0, b8 = '0, p8;
    logic [6:0] cx8 = '0, cy8 = '0, ox8, oy8;
    csm_array_mult #(.N(8)) uut (.a(a8), .b(b8), .cin_x(cx8), .cin_y(cy8),
                                 .plo(p8), .cout_x(ox8), .cout_y(oy8));
    // N = 4 instance
    logic [3:0] a4 = '0, b4 = '0, p4;
    logic [2:0] cx4 = '0, cy4 = '0, ox4, oy4;
    csm_array_mult #(.N(4)) uut4 (.a(a4), .b(b4), .cin_x(cx4), .cin_y(cy4),
                                  .plo(p4), .cout_x(ox4), .cout_y(oy4));
    // N = 3 instance
    logic [2:0] a3 = '0, b3 = '0, p3;
    logic [1:0] cx3 = '0, cy3 = '0, ox3, oy3;
    csm_array_mult #(.N(3)) uut3 (.a(a3), .b(b3), .cin_x(cx3), .cin_y(cy3),
                                  .plo(p3), .cout_x(ox3), .cout_y(oy3));
    // N = 2 instance
    logic [1:0] a2 = '0, b2 = '0, p2;
    logic [0:0] cx2 = '0, cy2 = '0, ox2, oy2;
    csm_array_mult #(.N(2)) uut2 (.a(a2), .b(b2), .cin_x(cx2), .cin_y(cy2),
                                  .plo(p2), .cout_x(ox2), .cout_y(oy2));
    // N = 1 instance
    logic [0:0] a1 = '0, b1 = '0, p1;
    logic [0:0] cx1 = '0, cy1 = '0, ox1, oy1;
    csm_array_mult #(.N(1)) uut1 (.a(a1), .b(b1), .cin_x(cx1), .cin_y(cy1),
                                  .plo(p1), .cout_x(ox1), .cout_y(oy1));

    // One comparison: counts it and prints a line on mismatch.
    task automatic check(input string req, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Arithmetic checks common to every width (R1, R2, R3).
    task automatic judge(input int n, input longint cin, input longint av, input longint bv,
                         input longint plov, input longint coutv);
        longint full = cin + av * bv;
        longint mask = (longint'(1) << n) - 1;
        check($sformatf("R1 n=%0d", n), plov + (coutv << n), full);
        check($sformatf("R3 n=%0d", n), plov, full & mask);
        check($sformatf("R2 n=%0d", n), longint'(coutv <= mask - 1), 1);
    endtask

    // Drive the N = 8 instance for one cycle, then judge at the falling edge.
    task automatic run8(input logic [7:0] av, input logic [7:0] bv,
                        input logic [6:0] xv, input logic [6:0] yv);
        @(posedge clk);
        a8 = av; b8 = bv; cx8 = xv; cy8 = yv;
        @(negedge clk);
        judge(8, longint'(xv) + longint'(yv), longint'(av), longint'(bv),
              longint'(p8), longint'(ox8) + longint'(oy8));
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // Idle state with all inputs zero: outputs zero (R4)
        @(negedge clk);
        check("R4 idle plo", longint'(p8), 0);
        check("R4 idle cout", longint'(ox8) + longint'(oy8), 0);

        // N = 1: carry-in tied 0, plo = a AND b, carry-out 0 (R8)
        for (int av = 0; av < 2; av++) begin
            for (int bv = 0; bv < 2; bv++) begin
                @(posedge clk);
                a1 = 1'(av); b1 = 1'(bv);
                @(negedge clk);
                check("R8 plo", longint'(p1), longint'(av & bv));
                check("R8 cout_x", longint'(ox1), 0);
                check("R8 cout_y", longint'(oy1), 0);
            end
        end

        // N = 2 exhaustive (R1 R2 R3)
        for (int av = 0; av < 4; av++)
            for (int bv = 0; bv < 4; bv++)
                for (int xv = 0; xv < 2; xv++)
                    for (int yv = 0; yv < 2; yv++) begin
                        @(posedge clk);
                        a2 = 2'(av); b2 = 2'(bv); cx2 = 1'(xv); cy2 = 1'(yv);
                        @(negedge clk);
                        judge(2, xv + yv, av, bv, p2, longint'(ox2) + longint'(oy2));
                    end

        // N = 3 exhaustive (R1 R2 R3)
        for (int av = 0; av < 8; av++)
            for (int bv = 0; bv < 8; bv++)
                for (int xv = 0; xv < 4; xv++)
                    for (int yv = 0; yv < 4; yv++) begin
                        @(posedge clk);
                        a3 = 3'(av); b3 = 3'(bv); cx3 = 2'(xv); cy3 = 2'(yv);
                        @(negedge clk);
                        judge(3, xv + yv, av, bv, p3, longint'(ox3) + longint'(oy3));
                    end

        // N = 4 exhaustive, including the largest carry-in 14 (R1 R2 R3)
        for (int av = 0; av < 16; av++)
            for (int bv = 0; bv < 16; bv++)
                for (int xv = 0; xv < 8; xv++)
                    for (int yv = 0; yv < 8; yv++) begin
                        @(posedge clk);
                        a4 = 4'(av); b4 = 4'(bv); cx4 = 3'(xv); cy4 = 3'(yv);
                        @(negedge clk);
                        judge(4, xv + yv, av, bv, p4, longint'(ox4) + longint'(oy4));
                    end

        // N = 8 directed: largest operands and carry-in give plo 255, cout 254 (R2)
        run8(8'hFF, 8'hFF, 7'h7F, 7'h7F);
        check("R2 max plo", longint'(p8), 255);
        check("R2 max cout", longint'(ox8) + longint'(oy8), 254);

        // Zero operand passes the carry-in straight to plo (R4)
        run8(8'h00, 8'hC3, 7'h55, 7'h2A);
        check("R4 a zero plo", longint'(p8), 'h55 + 'h2A);
        check("R4 a zero cout", longint'(ox8) + longint'(oy8), 0);
        run8(8'hA7, 8'h00, 7'h7F, 7'h7F);
        check("R4 b zero plo", longint'(p8), 254);
        check("R4 b zero cout", longint'(ox8) + longint'(oy8), 0);

        // One-hot multiplier selects a shifted multiplicand (R7)
        for (int j = 0; j < 8; j++) begin
            run8(8'hB5, 8'(1 << j), 7'h00, 7'h00);
            check($sformatf("R7 shift %0d", j),
                  longint'(p8) + ((longint'(ox8) + longint'(oy8)) << 8),
                  longint'('hB5) << j);
        end

        // Random vectors; carry-in vectors drawn freely stay within bound (R1 R2 R3)
        for (int k = 0; k < 10000; k++) begin
            run8(8'($urandom), 8'($urandom), 7'($urandom), 7'($urandom));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule